// File: doc/BRIEF.md
# Sorted Neighbor-List Intersection Triangle Counter

This block counts triangles for one graph edge at a time. For an edge (u, v), it receives the sorted neighbor list of each endpoint on its own valid/ready stream. Each stream marks its final element with a last flag. A two-pointer merge walks both lists together and finds the ids they share. A shared id forms a triangle with the edge, and it is counted only when it is larger than both endpoint ids. This keeps a single orientation, so each triangle is seen exactly once across the whole graph.

When both lists have ended, the block presents the edge's count with a one-cycle valid strobe. It also adds that count to a wide running total. A start strobe clears the total before a new graph is processed. The endpoint ids are inputs that the source holds steady while the edge's lists are in flight. Fetching lists from memory and storing results per node are left to the surrounding logic.

Top module: `tri_isect_counter`

## Requirements
- R1: While neither list has ended and both heads are valid, only the stream with the smaller head id is accepted (ready high). On equal heads, both streams are accepted in the same cycle.
- R2: An id present in both lists adds one to the edge count only when it is strictly greater than both `edge_u` and `edge_v`. An id equal to either endpoint id adds nothing.
- R3: `cnt_valid` is high for exactly the cycle after the handshake that consumes the second of the two last-marked elements, and `cnt_out` then holds the edge's count.
- R4: Once one list has delivered its last element, the other stream is accepted whenever it is valid, until its own last element arrives. Elements taken in this way are never counted.
- R5: `total_out` changes in the same cycle as `cnt_valid`, and then equals its previous value plus `cnt_out`.
- R6: A start strobe makes `total_out` zero on the next cycle. If an edge completes in that same cycle, its count is not added to the total.
- R7: While neither list has ended, neither stream is accepted unless both are valid. No ready is ever given to a stream whose valid is low.
- R8: After reset, `cnt_valid` is low, `cnt_out` and `total_out` are zero, and no ready is raised while no valid is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Clears the running total |
| edge_u | input | ID_W | First endpoint id, held for the whole edge |
| edge_v | input | ID_W | Second endpoint id, held for the whole edge |
| a_valid | input | 1 | List A element present |
| a_data | input | ID_W | List A element id, ascending |
| a_last | input | 1 | Marks list A's final element |
| a_ready | output | 1 | List A element accepted |
| b_valid | input | 1 | List B element present |
| b_data | input | ID_W | List B element id, ascending |
| b_last | input | 1 | Marks list B's final element |
| b_ready | output | 1 | List B element accepted |
| cnt_valid | output | 1 | One-cycle strobe: edge count ready |
| cnt_out | output | CNT_W | Triangle count for the finished edge |
| total_out | output | ACC_W | Running triangle total |

## Verification
A stuck list-ended flag shows at the ready outputs in the very next cycle. A stream would be drained although it should be compared, or it would stall although it should be drained. In either case the pair of lists then ends on the wrong cycle, and the edge's `cnt_out` differs from the bench's own intersection count. A wrong per-edge counter or filter shows in `cnt_out` when that edge ends. A total that was corrupted, or not cleared by start, stays visible in `total_out` at every later strobe.

// File: rtl/tri_pkg.sv
package tri_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_A    = 2'd1,
      STEP_B    = 2'd2,
      STEP_BOTH = 2'd3
   } step_e;

   function automatic step_e pick_step(input logic lt, input logic eq);
      if (eq)      return STEP_BOTH;
      else if (lt) return STEP_A;
      else         return STEP_B;
   endfunction
endpackage

// File: rtl/tri_merge_step.sv
module tri_merge_step
   import tri_pkg::*;
#(
   parameter int ID_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            a_valid,
   input  logic [ID_W-1:0] a_data,
   input  logic            a_last,
   output logic            a_ready,
   input  logic            b_valid,
   input  logic [ID_W-1:0] b_data,
   input  logic            b_last,
   output logic            b_ready,
   output logic            hit,
   output logic            edge_end,
   output logic            a_done,
   output logic            b_done
);
   step_e step;
   logic  a_fire, b_fire, a_end, b_end;

   always_comb begin
      step = STEP_HOLD;
      if (!a_done && !b_done) begin
         if (a_valid && b_valid) step = pick_step(a_data < b_data, a_data == b_data);
      end else if (a_done && !b_done) begin
         if (b_valid) step = STEP_B;
      end else if (b_done && !a_done) begin
         if (a_valid) step = STEP_A;
      end
   end

   assign a_ready  = (step == STEP_A) || (step == STEP_BOTH);
   assign b_ready  = (step == STEP_B) || (step == STEP_BOTH);
   assign hit      = (step == STEP_BOTH);
   assign a_fire   = a_valid && a_ready;
   assign b_fire   = b_valid && b_ready;
   assign a_end    = a_done || (a_fire && a_last);
   assign b_end    = b_done || (b_fire && b_last);
   assign edge_end = a_end && b_end && (a_fire || b_fire);

   always_ff @(posedge clk) begin
      if (!rst_n || edge_end) begin
         a_done <= 1'b0;
         b_done <= 1'b0;
      end else begin
         a_done <= a_end;
         b_done <= b_end;
      end
   end
endmodule

// File: rtl/tri_dir_filter.sv
module tri_dir_filter #(
   parameter int ID_W       = 16,
   parameter bit DIR_FILTER = 1'b1
) (
   input  logic            hit,
   input  logic [ID_W-1:0] id,
   input  logic [ID_W-1:0] end_u,
   input  logic [ID_W-1:0] end_v,
   output logic            inc
);
   generate
      if (DIR_FILTER) begin : g_oriented
         assign inc = hit && (id > end_u) && (id > end_v);
      end else begin : g_plain
         logic unused_ids;
         assign unused_ids = ^{id, end_u, end_v};
         assign inc = hit;
      end
   endgenerate
endmodule

// File: rtl/tri_accum.sv
module tri_accum #(
   parameter int CNT_W = 16,
   parameter int ACC_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             inc,
   input  logic             edge_end,
   output logic             cnt_valid,
   output logic [CNT_W-1:0] cnt_out,
   output logic [ACC_W-1:0] total_out
);
   localparam int PAD_W = ACC_W - CNT_W;

   logic [CNT_W-1:0] edge_cnt, edge_fin;

   assign edge_fin = edge_cnt + CNT_W'(inc);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         edge_cnt  <= '0;
         cnt_out   <= '0;
         cnt_valid <= 1'b0;
         total_out <= '0;
      end else begin
         cnt_valid <= edge_end;
         if (edge_end) begin
            edge_cnt <= '0;
            cnt_out  <= edge_fin;
         end else begin
            edge_cnt <= edge_fin;
         end
         if (start)         total_out <= '0;
         else if (edge_end) total_out <= total_out + {{PAD_W{1'b0}}, edge_fin};
      end
   end
endmodule

// File: rtl/tri_isect_counter.sv
module tri_isect_counter #(
   parameter int ID_W       = 16,
   parameter int CNT_W      = 16,
   parameter int ACC_W      = 64,
   parameter bit DIR_FILTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [ID_W-1:0]  edge_u,
   input  logic [ID_W-1:0]  edge_v,
   input  logic             a_valid,
   input  logic [ID_W-1:0]  a_data,
   input  logic             a_last,
   output logic             a_ready,
   input  logic             b_valid,
   input  logic [ID_W-1:0]  b_data,
   input  logic             b_last,
   output logic             b_ready,
   output logic             cnt_valid,
   output logic [CNT_W-1:0] cnt_out,
   output logic [ACC_W-1:0] total_out
);
   generate
      if (ID_W < 2)      begin : g_bad_id  $error("ID_W must be at least 2");        end
      if (CNT_W < 1)     begin : g_bad_cnt $error("CNT_W must be at least 1");       end
      if (ACC_W < CNT_W) begin : g_bad_acc $error("ACC_W must not be below CNT_W"); end
   endgenerate

   logic hit, inc, edge_end, a_done_q, b_done_q;

   tri_merge_step #(.ID_W(ID_W)) u_merge (
      .clk(clk), .rst_n(rst_n),
      .a_valid(a_valid), .a_data(a_data), .a_last(a_last), .a_ready(a_ready),
      .b_valid(b_valid), .b_data(b_data), .b_last(b_last), .b_ready(b_ready),
      .hit(hit), .edge_end(edge_end), .a_done(a_done_q), .b_done(b_done_q)
   );

   tri_dir_filter #(.ID_W(ID_W), .DIR_FILTER(DIR_FILTER)) u_filter (
      .hit(hit), .id(a_data), .end_u(edge_u), .end_v(edge_v), .inc(inc)
   );

   tri_accum #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .start(start), .inc(inc), .edge_end(edge_end),
      .cnt_valid(cnt_valid), .cnt_out(cnt_out), .total_out(total_out)
   );
endmodule

// File: rtl/tri_isect_counter_chk.sv
module tri_isect_counter_chk #(
   parameter int ID_W  = 16,
   parameter int CNT_W = 16,
   parameter int ACC_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             a_valid,
   input logic [ID_W-1:0]  a_data,
   input logic             a_ready,
   input logic             b_valid,
   input logic [ID_W-1:0]  b_data,
   input logic             b_ready,
   input logic             a_done_q,
   input logic             b_done_q,
   input logic             cnt_valid,
   input logic [CNT_W-1:0] cnt_out,
   input logic [ACC_W-1:0] total_out
);
   localparam int PAD_W = ACC_W - CNT_W;

   a_r1_both_on_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (a_ready && b_ready) |-> (a_valid && b_valid && a_data == b_data));
   a_r1_a_smaller: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_done_q && !b_done_q && a_ready && !b_ready) |-> (a_data < b_data));
   a_r1_b_smaller: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_done_q && !b_done_q && b_ready && !a_ready) |-> (b_data < a_data));
   a_r4_drain_b: assert property (@(posedge clk) disable iff (!rst_n)
      (a_done_q && !b_done_q && b_valid) |-> (b_ready && !a_ready));
   a_r4_drain_a: assert property (@(posedge clk) disable iff (!rst_n)
      (b_done_q && !a_done_q && a_valid) |-> (a_ready && !b_ready));
   a_r5_total_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_valid && !$past(start)) |-> (total_out == $past(total_out) + {{PAD_W{1'b0}}, cnt_out}));
   a_r5_total_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_valid && !$past(start)) |-> $stable(total_out));
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (total_out == '0));
   a_r7_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (!(a_ready && !a_valid)) && (!(b_ready && !b_valid)));
   a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_done_q && !b_done_q && !(a_valid && b_valid)) |-> (!a_ready && !b_ready));
endmodule

bind tri_isect_counter tri_isect_counter_chk #(.ID_W(ID_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start),
   .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
   .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready),
   .a_done_q(a_done_q), .b_done_q(b_done_q),
   .cnt_valid(cnt_valid), .cnt_out(cnt_out), .total_out(total_out)
);

// File: tb/tri_isect_counter_tb.sv
module tri_isect_counter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ID_W = 16, CNT_W = 16, ACC_W = 64;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [ID_W-1:0] edge_u = '0, edge_v = '0, a_data = '0, b_data = '0;
   logic a_valid = 1'b0, a_last = 1'b0, b_valid = 1'b0, b_last = 1'b0;
   logic a_ready, b_ready, cnt_valid;
   logic [CNT_W-1:0] cnt_out;
   logic [ACC_W-1:0] total_out;

   int tests = 0, fails = 0;
   longint shadow_total = 0;
   int la[32], lb[32];

   always #(CLK_PERIOD/2) clk = ~clk;

   tri_isect_counter #(.ID_W(ID_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .edge_u(edge_u), .edge_v(edge_v),
      .a_valid(a_valid), .a_data(a_data), .a_last(a_last), .a_ready(a_ready),
      .b_valid(b_valid), .b_data(b_data), .b_last(b_last), .b_ready(b_ready),
      .cnt_valid(cnt_valid), .cnt_out(cnt_out), .total_out(total_out)
   );

   task automatic check(string req, longint act, longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Streams one edge; gaps drop valid on every gN-th cycle (0 = none).
   task automatic run_edge(string tag, int u, int v, int na, int nb, int ga, int gb);
      int exp_cnt = 0, ia = 0, ib = 0, cyc = 0;
      bit got = 0, drain_seen = 0, fa, fb;
      for (int i = 0; i < na; i++)
         for (int j = 0; j < nb; j++)
            if (la[i] == lb[j] && la[i] > u && la[i] > v) exp_cnt++;
      shadow_total += exp_cnt;
      edge_u = ID_W'(u);
      edge_v = ID_W'(v);
      while (!got && cyc < 400) begin
         @(negedge clk);
         if (cnt_valid) begin
            got = 1;
            check({tag, " R2 R3 cnt_out"}, longint'(cnt_out), exp_cnt);
            check({tag, " R5 total_out"}, longint'(total_out), shadow_total);
         end else begin
            a_valid = (ia < na) && !(ga > 0 && (cyc % ga) == ga - 1);
            a_data  = ID_W'(la[(ia < na) ? ia : 0]);
            a_last  = (ia == na - 1);
            b_valid = (ib < nb) && !(gb > 0 && (cyc % gb) == gb - 1);
            b_data  = ID_W'(lb[(ib < nb) ? ib : 0]);
            b_last  = (ib == nb - 1);
            #1;
            fa = a_valid && a_ready;
            fb = b_valid && b_ready;
            if (!drain_seen && ia >= na && ib < nb && b_valid) begin
               drain_seen = 1;
               check({tag, " R4 drain b_ready"}, longint'(b_ready), 1);
            end
            if (!drain_seen && ib >= nb && ia < na && a_valid) begin
               drain_seen = 1;
               check({tag, " R4 drain a_ready"}, longint'(a_ready), 1);
            end
            @(posedge clk);
            if (fa) ia++;
            if (fb) ib++;
            cyc++;
         end
      end
      a_valid = 1'b0;
      b_valid = 1'b0;
      if (!got) check({tag, " R3 cnt_valid never seen"}, 0, 1);
      @(negedge clk);
      check({tag, " R3 strobe one cycle"}, longint'(cnt_valid), 0);
   endtask

   task automatic test_reset();
      @(negedge clk);
      check("R8 cnt_valid", longint'(cnt_valid), 0);
      check("R8 cnt_out", longint'(cnt_out), 0);
      check("R8 total_out", longint'(total_out), 0);
      check("R8 ready idle", longint'({a_ready, b_ready}), 0);
   endtask

   task automatic test_worked();
      la[0:3] = '{2, 3, 4, 5};
      lb[0:4] = '{1, 3, 5, 6, 7};
      run_edge("worked", 1, 2, 4, 5, 0, 0);
   endtask

   task automatic test_filter();
      la[0:4] = '{3, 4, 6, 7, 9};
      lb[0:4] = '{1, 3, 6, 7, 8};
      run_edge("filter", 5, 2, 5, 5, 0, 0);
   endtask

   task automatic test_endpoint_equal();
      la[0:1] = '{6, 7};
      lb[0:1] = '{6, 7};
      run_edge("R2 boundary", 4, 6, 2, 2, 0, 0);
   endtask

   task automatic test_disjoint();
      la[0:2] = '{1, 3, 5};
      lb[0:2] = '{2, 4, 6};
      run_edge("disjoint", 0, 0, 3, 3, 0, 0);
   endtask

   task automatic test_drain();
      la[0] = 1;
      lb[0:3] = '{1, 2, 3, 4};
      run_edge("drain b", 0, 0, 1, 4, 0, 0);
      la[0:3] = '{2, 5, 8, 9};
      lb[0] = 5;
      run_edge("drain a", 0, 0, 4, 1, 0, 0);
   endtask

   task automatic test_gaps();
      la[0:7] = '{0, 2, 4, 6, 8, 10, 12, 14};
      lb[0:7] = '{3, 4, 5, 6, 9, 10, 14, 15};
      run_edge("gaps", 1, 3, 8, 8, 3, 2);
   endtask

   task automatic test_stall();
      @(negedge clk);
      a_valid = 1'b1; a_data = 16'd5; a_last = 1'b1; b_valid = 1'b0;
      #1;
      check("R7 stall a_ready", longint'(a_ready), 0);
      check("R7 no ready without valid", longint'(b_ready), 0);
      @(negedge clk);
      a_valid = 1'b0;
   endtask

   task automatic test_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      shadow_total = 0;
      check("R6 total cleared", longint'(total_out), 0);
      la[0] = 9;
      lb[0] = 9;
      run_edge("after start single", 1, 2, 1, 1, 0, 0);
      la[0] = 9;
      lb[0] = 9;
      run_edge("R6 repeat single", 1, 2, 1, 1, 0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_worked();
      test_filter();
      test_endpoint_equal();
      test_disjoint();
      test_drain();
      test_gaps();
      test_stall();
      test_start();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule